// File: doc/BRIEF.md
# Successive-Approximation Converter Control Sequencer

This block is the digital controller that sits beside a 12-bit successive-approximation analog core. Software programs it through a small register port. The fields choose one of four conversion-clock tick sources and a divide ratio, one of four sample triggers, the sampling style, the input channel and the internal reference. The sequencer then samples the selected channel and runs a bit-by-bit search against the comparator answer returned by the analog core. It posts the 12-bit code together with a one-cycle completion strobe.

Two sampling styles exist. In the timed style, a rising trigger edge opens a window of a fixed number of divided clock ticks. In the pulse-width style, the window is the high time of the trigger itself, and conversion begins on its falling edge. The core is awake only while a conversion is in flight. The reference stays powered until software clears its enable. Conversions wait until the reference settle counter reports ready. Clearing the conversion enable during a conversion is held back until that conversion has finished, so the result cannot be corrupted.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The 2-bit clock-select field (CLK register bits 1:0) picks which of the four `src_tick` inputs feeds the divider.
- R2: The divider emits one conversion tick per (div+1) selected source ticks, with div taken from CLK register bits 4:2.
- R3: The trigger-select field (CTRL bits 7:6) picks the sample signal: 0 is the software sample bit (CTRL bit 2), 1 is `hw_trig[0]` (timer A), 2 is `hw_trig[1]` and 3 is `hw_trig[2]` (timer B outputs). Unselected triggers start nothing.
- R4: In timed mode (CTRL bit 3 = 0), a rising edge of the selected trigger opens a sample window of SAMP_TICKS divided ticks, and conversion follows at once.
- R5: In pulse-width mode (CTRL bit 3 = 1), sampling lasts while the trigger is high, and conversion starts only at its falling edge.
- R6: Conversion takes 12 divided ticks and resolves bits MSB first against `cmp_in` (1 means the input is at or above `dac_code`). An input at or above full scale yields 0xFFF, and an input of zero yields 0x000.
- R7: `done` is high for exactly one cycle, in the cycle after `busy` falls. `result` changes only with `done` and then holds.
- R8: `core_awake` is high only while a conversion is in flight, and low whenever the block is idle.
- R9: The reference enable (CTRL bit 4, level in bit 5) drives `ref_enable` until software clears it. Status bit 1 reports ready REF_SETTLE_CYC cycles after enabling. While the reference is enabled and not ready, triggers are ignored.
- R10: Writing the conversion enable (CTRL bit 1) to 0 while busy is deferred. Status bit 2 keeps reading 1 and pending bit 3 reads 1 until the conversion ends, after which the enable clears.
- R11: The channel field (CLK bits 10:8) is latched onto `mux_chan` at the start of sampling. Later writes do not affect the running conversion.
- R12: With the core-on bit (CTRL bit 0) cleared, or the conversion enable cleared, triggers are ignored and `busy` stays low.
- R13: After reset all registers, `busy`, `done`, `result`, `core_awake` and `ref_enable` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 clock/channel, 2 status, 3 result) |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data for `addr` |
| src_tick | input | 4 | Tick strobes of the four candidate conversion clocks |
| hw_trig | input | 3 | Hardware sample triggers (timer A, two timer B outputs) |
| cmp_in | input | 1 | Comparator answer from the analog core |
| dac_code | output | 12 | Trial code presented to the analog core |
| mux_chan | output | 3 | Latched input channel |
| core_awake | output | 1 | Analog core power request |
| ref_enable | output | 1 | Internal reference power enable |
| ref_level_hi | output | 1 | Reference level select (1 = higher level) |
| result | output | 12 | Last conversion code |
| busy | output | 1 | Sampling or converting |
| done | output | 1 | One-cycle completion strobe |

## Verification
A vector table exercises every trigger source, both sampling styles, all four clock sources and several divide ratios. The analog values cover mid-scale, a single LSB, one below full scale, exactly full scale, above full scale and zero. Unselected channels hold a different value, so a wrong channel latch shows up as a wrong code. Completion time is bracketed by the expected tick period, which separates the clock-select and divider settings and separates the timed style from the pulse-width style. Directed cases cover the reference settle gate, a deferred enable clear, a channel rewrite during sampling and triggers with the core switched off.

// File: rtl/adc_seq_pkg.sv
// Shared register map, field positions and sequencer state type.
// Assumes the default field widths fit in a 16-bit register word.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_CLK  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_RES  = 2'd3;

    // control register bit positions
    localparam int CB_CORE  = 0;
    localparam int CB_EN    = 1;
    localparam int CB_SW    = 2;
    localparam int CB_EXT   = 3;
    localparam int CB_REF   = 4;
    localparam int CB_REFHI = 5;
    localparam int CB_TRIG  = 6;

    // clock/channel register field positions
    localparam int KB_CSEL = 0;
    localparam int KB_DIV  = 2;
    localparam int KB_CHAN = 8;

    // status register bit positions
    localparam int SB_BUSY  = 0;
    localparam int SB_READY = 1;
    localparam int SB_EN    = 2;
    localparam int SB_PEND  = 3;

endpackage

// File: rtl/adc_clk_div.sv
// Conversion clock generator: selects one tick source and divides it.
// Assumes src_tick strobes are synchronous to clk. The count restarts
// whenever run is low, so each conversion begins with a fresh period.
module adc_clk_div #(
    parameter int N_SRC = 4,
    parameter int DIV_W = 3,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             sel_tick;

    // pick the chosen source strobe
    assign sel_tick = src_tick[sel];
    // a divided tick is the selected strobe that completes a period
    assign tick = run && sel_tick && (cnt_q == div);

    // count selected strobes within one divided period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (sel_tick) begin
            cnt_q <= (cnt_q == div) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_ref_timer.sv
// Reference settle timer: counts cycles after the reference is enabled
// and reports ready once SETTLE_CYC cycles have elapsed. Disabling the
// reference clears the count. Assumes SETTLE_CYC >= 1.
module adc_ref_timer #(
    parameter int SETTLE_CYC = 1000,
    localparam int CW = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ready
);
    logic [CW-1:0] cnt_q;

    // ready once the full settle count is reached
    assign ready = (cnt_q == CW'(SETTLE_CYC));

    // count up while enabled, saturate at the settle value
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (!ready) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_sar_core.sv
// Bit-search engine: on start, clears the accumulator and resolves one
// bit per step, MSB first, keeping a bit when cmp_in says the input is at
// or above the trial code. fin pulses one cycle after the LSB step.
module adc_sar_core #(
    parameter int W = 12,
    localparam int IW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         step,
    input  logic         cmp_in,
    output logic [W-1:0] trial,
    output logic [W-1:0] value,
    output logic         fin
);
    logic [W-1:0]  acc_q;
    logic [IW-1:0] idx_q;
    logic          active_q;
    logic          fin_q;

    // trial code adds the bit under test to the kept bits
    assign trial = active_q ? (acc_q | (W'(1) << idx_q)) : acc_q;
    assign value = acc_q;
    assign fin   = fin_q;

    // resolve one bit per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            idx_q    <= '0;
            active_q <= 1'b0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (abort) begin
                active_q <= 1'b0;
            end else if (start) begin
                acc_q    <= '0;
                idx_q    <= IW'(W - 1);
                active_q <= 1'b1;
            end else if (active_q && step) begin
                if (cmp_in) begin
                    acc_q[idx_q] <= 1'b1;
                end
                if (idx_q == '0) begin
                    active_q <= 1'b0;
                    fin_q    <= 1'b1;
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the converter control sequencer. Holds the register file,
// selects the sample trigger, runs the idle/sample/convert sequence and
// posts results. Assumes all inputs are synchronous to clk and that the
// default field widths fit the register layout in adc_seq_pkg.
module adc_seq_ctrl #(
    parameter int RES_W          = 12,
    parameter int N_CHAN         = 8,
    parameter int N_SRC          = 4,
    parameter int DIV_W          = 3,
    parameter int N_HW_TRIG      = 3,
    parameter int SAMP_TICKS     = 4,
    parameter int REF_SETTLE_CYC = 1000,
    parameter int DATA_W         = 16,
    localparam int CH_W   = $clog2(N_CHAN),
    localparam int SEL_W  = $clog2(N_SRC),
    localparam int TSEL_W = $clog2(N_HW_TRIG + 1),
    localparam int SC_W   = $clog2(SAMP_TICKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [N_SRC-1:0]     src_tick,
    input  logic [N_HW_TRIG-1:0] hw_trig,
    input  logic                 cmp_in,
    output logic [RES_W-1:0]     dac_code,
    output logic [CH_W-1:0]      mux_chan,
    output logic                 core_awake,
    output logic                 ref_enable,
    output logic                 ref_level_hi,
    output logic [RES_W-1:0]     result,
    output logic                 busy,
    output logic                 done
);
    import adc_seq_pkg::*;

    // register file
    logic              core_on_q, enc_q, pend_clr_q, sw_q, ext_q;
    logic              ref_on_q, ref_hi_q;
    logic [TSEL_W-1:0] trig_sel_q;
    logic [SEL_W-1:0]  clk_sel_q;
    logic [DIV_W-1:0]  div_q;
    logic [CH_W-1:0]   chan_q;

    // sequencer state
    seq_state_t        state_q;
    logic [CH_W-1:0]   chan_lat_q;
    logic [SC_W-1:0]   samp_cnt_q;
    logic              samp_prev_q;
    logic [RES_W-1:0]  result_q;
    logic              done_q;

    logic              wr_ctrl, wr_clk;
    logic              samp_sig, samp_rise, samp_fall;
    logic              ref_ready, can_start, go_conv;
    logic              div_run, div_tick;
    logic              sar_start, sar_step, sar_fin;
    logic [RES_W-1:0]  sar_trial, sar_value;
    logic [N_HW_TRIG:0] trig_vec;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_clk  = wr_en && (addr == REG_CLK);
    assign busy    = (state_q != ST_IDLE);

    // control register with deferred clearing of the conversion enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_on_q  <= 1'b0;
            enc_q      <= 1'b0;
            pend_clr_q <= 1'b0;
            sw_q       <= 1'b0;
            ext_q      <= 1'b0;
            ref_on_q   <= 1'b0;
            ref_hi_q   <= 1'b0;
            trig_sel_q <= '0;
        end else if (wr_ctrl) begin
            core_on_q  <= wr_data[CB_CORE];
            sw_q       <= wr_data[CB_SW];
            ext_q      <= wr_data[CB_EXT];
            ref_on_q   <= wr_data[CB_REF];
            ref_hi_q   <= wr_data[CB_REFHI];
            trig_sel_q <= wr_data[CB_TRIG +: TSEL_W];
            if (!wr_data[CB_EN] && enc_q && busy) begin
                pend_clr_q <= 1'b1;
            end else begin
                enc_q      <= wr_data[CB_EN];
                pend_clr_q <= 1'b0;
            end
        end else if (pend_clr_q && !busy) begin
            enc_q      <= 1'b0;
            pend_clr_q <= 1'b0;
        end
    end

    // clock source, divider and channel register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel_q <= '0;
            div_q     <= '0;
            chan_q    <= '0;
        end else if (wr_clk) begin
            clk_sel_q <= wr_data[KB_CSEL +: SEL_W];
            div_q     <= wr_data[KB_DIV +: DIV_W];
            chan_q    <= wr_data[KB_CHAN +: CH_W];
        end
    end

    // trigger selection: index 0 is the software bit, then hardware inputs
    assign trig_vec  = {hw_trig, sw_q};
    assign samp_sig  = trig_vec[trig_sel_q];
    assign samp_rise = samp_sig && !samp_prev_q;
    assign samp_fall = !samp_sig && samp_prev_q;

    // remember the previous sample level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) samp_prev_q <= 1'b0;
        else        samp_prev_q <= samp_sig;
    end

    adc_ref_timer #(.SETTLE_CYC(REF_SETTLE_CYC)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ref_on_q),
        .ready (ref_ready)
    );

    assign div_run = (state_q == ST_CONV) || ((state_q == ST_SAMPLE) && !ext_q);

    adc_clk_div #(.N_SRC(N_SRC), .DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (div_run),
        .src_tick (src_tick),
        .sel      (clk_sel_q),
        .div      (div_q),
        .tick     (div_tick)
    );

    assign can_start = core_on_q && enc_q && !pend_clr_q && (!ref_on_q || ref_ready);
    assign go_conv   = ext_q ? samp_fall
                             : (div_tick && (samp_cnt_q == SC_W'(SAMP_TICKS - 1)));
    assign sar_start = (state_q == ST_SAMPLE) && core_on_q && go_conv;
    assign sar_step  = (state_q == ST_CONV) && div_tick;

    adc_sar_core #(.W(RES_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sar_start),
        .abort  (!core_on_q),
        .step   (sar_step),
        .cmp_in (cmp_in),
        .trial  (sar_trial),
        .value  (sar_value),
        .fin    (sar_fin)
    );

    // idle / sample / convert sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            chan_lat_q <= '0;
            samp_cnt_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (samp_rise && can_start) begin
                        state_q    <= ST_SAMPLE;
                        chan_lat_q <= chan_q;
                        samp_cnt_q <= '0;
                    end
                end
                ST_SAMPLE: begin
                    if (!core_on_q)              state_q <= ST_IDLE;
                    else if (go_conv)            state_q <= ST_CONV;
                    else if (!ext_q && div_tick) samp_cnt_q <= samp_cnt_q + 1'b1;
                end
                ST_CONV: begin
                    if (!core_on_q || sar_fin) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // post the result with a one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == ST_CONV) && core_on_q && sar_fin;
            if ((state_q == ST_CONV) && core_on_q && sar_fin) begin
                result_q <= sar_value;
            end
        end
    end

    // register read mux
    always_comb begin
        rd_data = '0;
        case (addr)
            REG_CTRL: begin
                rd_data[CB_CORE]            = core_on_q;
                rd_data[CB_EN]              = enc_q;
                rd_data[CB_SW]              = sw_q;
                rd_data[CB_EXT]             = ext_q;
                rd_data[CB_REF]             = ref_on_q;
                rd_data[CB_REFHI]           = ref_hi_q;
                rd_data[CB_TRIG +: TSEL_W]  = trig_sel_q;
            end
            REG_CLK: begin
                rd_data[KB_CSEL +: SEL_W]   = clk_sel_q;
                rd_data[KB_DIV +: DIV_W]    = div_q;
                rd_data[KB_CHAN +: CH_W]    = chan_q;
            end
            REG_STAT: begin
                rd_data[SB_BUSY]            = busy;
                rd_data[SB_READY]           = ref_ready;
                rd_data[SB_EN]              = enc_q;
                rd_data[SB_PEND]            = pend_clr_q;
            end
            default: begin
                rd_data[RES_W-1:0]          = result_q;
            end
        endcase
    end

    assign dac_code     = sar_trial;
    assign mux_chan     = chan_lat_q;
    assign core_awake   = busy;
    assign ref_enable   = ref_on_q;
    assign ref_level_hi = ref_hi_q;
    assign result       = result_q;
    assign done         = done_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Property checker for adc_seq_ctrl, attached by bind. Observes ports
// and a few register-file bits; drives nothing.
module adc_seq_ctrl_chk #(
    parameter int RES_W = 12,
    parameter int CH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] result,
    input logic [CH_W-1:0]  mux_chan,
    input logic             core_on,
    input logic             enc,
    input logic             ref_on,
    input logic             ref_ready
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> done);
    // R11
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_chan));
    // R10
    enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enc) |-> !$past(busy));
    // R12
    core_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_on |=> !busy);
    // R9
    ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!ref_on || ref_ready));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .mux_chan  (mux_chan),
    .core_on   (core_on_q),
    .enc       (enc_q),
    .ref_on    (ref_on_q),
    .ref_ready (ref_ready)
);

// File: tb/adc_seq_ctrl_bench.sv
// Bench for adc_seq_ctrl: table-driven conversions, then directed cases.
module adc_seq_ctrl_bench;
    localparam int REF_CYC = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [3:0]  src_tick = 4'b0001;
    logic [2:0]  hw_trig = 3'b000;
    logic        cmp_in;
    logic [11:0] dac_code;
    logic [2:0]  mux_chan;
    logic        core_awake, ref_enable, ref_level_hi, busy, done;
    logic [11:0] result;

    logic [12:0] vin_ch [8];
    int cyc = 0, n_cmp = 0, n_bad = 0, done_cnt = 0;
    bit finished = 0;

    adc_seq_ctrl #(.REF_SETTLE_CYC(REF_CYC)) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .src_tick(src_tick),
        .hw_trig(hw_trig), .cmp_in(cmp_in), .dac_code(dac_code),
        .mux_chan(mux_chan), .core_awake(core_awake), .ref_enable(ref_enable),
        .ref_level_hi(ref_level_hi), .result(result), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) done_cnt <= done_cnt + 1;
    end
    // behavioural analog core: input at or above the trial code answers 1
    always_comb cmp_in = (vin_ch[mux_chan] >= {1'b0, dac_code});

    // tick sources: source k strobes every k+1 cycles (R1)
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = ph + 1;
            src_tick[0] = 1'b1;
            src_tick[1] = (ph % 2) == 0;
            src_tick[2] = (ph % 3) == 0;
            src_tick[3] = (ph % 4) == 0;
        end
    end

    // {trig(2) ext(1) csel(2) div(3) chan(3) vin(13) expected(12)}
    localparam logic [35:0] VECS [8] = '{
        {2'd0, 1'b0, 2'd0, 3'd0, 3'd0, 13'd1234, 12'd1234},
        {2'd1, 1'b0, 2'd1, 3'd1, 3'd3, 13'd4095, 12'hFFF},
        {2'd2, 1'b1, 2'd0, 3'd2, 3'd5, 13'd0,    12'h000},
        {2'd3, 1'b0, 2'd2, 3'd0, 3'd7, 13'd4200, 12'hFFF},
        {2'd1, 1'b1, 2'd3, 3'd0, 3'd1, 13'd2048, 12'd2048},
        {2'd0, 1'b1, 2'd0, 3'd1, 3'd2, 13'd1,    12'd1},
        {2'd3, 1'b1, 2'd1, 3'd0, 3'd6, 13'd2730, 12'd2730},
        {2'd2, 1'b0, 2'd0, 3'd7, 3'd4, 13'd4094, 12'd4094}
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [15:0] ctrl_w(input bit core, input bit en, input bit sw,
            input bit ext, input bit rf, input bit rhi, input logic [1:0] trig);
        return {8'd0, trig, rhi, rf, ext, sw, en, core};
    endfunction

    function automatic logic [15:0] clk_w(input logic [1:0] cs, input logic [2:0] dv,
            input logic [2:0] ch);
        return {5'd0, ch, 3'd0, dv, cs};
    endfunction

    task automatic wait_done(input int maxc, output int at, output bit ok);
        ok = 0; at = 0;
        for (int k = 0; k < maxc; k++) begin
            @(negedge clk);
            if (done) begin ok = 1; at = cyc; break; end
        end
    endtask

    task automatic pulse_hw(input int b, input int hold);
        @(negedge clk); hw_trig[b] = 1'b1;
        repeat (hold) @(negedge clk);
        hw_trig[b] = 1'b0;
    endtask

    // raise the selected trigger (software bit or hardware input)
    task automatic trig_set(input logic [1:0] trig, input bit ext, input bit lvl);
        if (trig == 2'd0) reg_wr(2'd0, ctrl_w(1, 1, lvl, ext, 0, 0, 2'd0));
        else begin @(negedge clk); hw_trig[trig - 1] = lvl; end
    endtask

    task automatic run_vec(input int i, input logic [35:0] v);
        logic [1:0] trig, csel; logic ext; logic [2:0] dv, ch;
        logic [12:0] vin; logic [11:0] exp;
        int P, t0, td, dc0; bit ok;
        {trig, ext, csel, dv, ch, vin, exp} = v;
        P = (int'(dv) + 1) * (int'(csel) + 1);
        for (int c = 0; c < 8; c++) vin_ch[c] = 13'd3000;
        vin_ch[ch] = vin;
        reg_wr(2'd1, clk_w(csel, dv, ch));
        reg_wr(2'd0, ctrl_w(1, 1, 0, ext, 0, 0, trig));
        // an unselected hardware trigger must start nothing (R3)
        pulse_hw(int'(trig) % 3, 2);
        repeat (3) @(negedge clk);
        check($sformatf("R3 vec%0d unselected trigger busy", i), busy, 0);
        t0 = cyc;
        trig_set(trig, ext, 1);
        if (ext) begin
            dc0 = done_cnt;
            repeat (16 * P + 20) @(negedge clk);
            check($sformatf("R5 vec%0d busy while held", i), busy, 1);
            check($sformatf("R5 vec%0d no done while held", i), done_cnt - dc0, 0);
            t0 = cyc;
            trig_set(trig, ext, 0);
            wait_done(40 * P + 50, td, ok);
            check($sformatf("R5 vec%0d done seen", i), ok, 1);
            check($sformatf("R1 R2 R6 vec%0d time after fall in window", i),
                  int'((td - t0) >= 11 * P && (td - t0) <= 12 * P + 6), 1);
        end else begin
            trig_set(trig, ext, 0);
            wait_done(40 * P + 50, td, ok);
            check($sformatf("R4 vec%0d done seen", i), ok, 1);
            check($sformatf("R1 R2 R4 vec%0d time in window", i),
                  int'((td - t0) >= 15 * P && (td - t0) <= 16 * P + 6), 1);
        end
        check($sformatf("R6 R11 vec%0d result", i), result, exp);
        @(negedge clk);
        check($sformatf("R7 vec%0d done one cycle", i), done, 0);
        check($sformatf("R8 vec%0d core asleep when idle", i), core_awake, 0);
    endtask

    initial begin
        logic [15:0] d;
        int td; bit ok;
        for (int c = 0; c < 8; c++) vin_ch[c] = 13'd3000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        reg_rd(2'd0, d); check("R13 ctrl after reset", d, 0);
        reg_rd(2'd2, d); check("R13 status after reset", d, 0);
        reg_rd(2'd3, d); check("R13 result after reset", d, 0);
        check("R13 busy/done/awake/ref after reset",
              {busy, done, core_awake, ref_enable}, 0);

        for (int i = 0; i < 8; i++) run_vec(i, VECS[i]);

        // R12: core off, triggers ignored
        reg_wr(2'd1, clk_w(2'd0, 3'd0, 3'd0));
        reg_wr(2'd0, ctrl_w(0, 1, 0, 0, 0, 0, 2'd1));
        pulse_hw(0, 2);
        repeat (40) @(negedge clk);
        check("R12 busy stays low with core off", busy, 0);
        // R12: enable cleared, triggers ignored
        reg_wr(2'd0, ctrl_w(1, 0, 0, 0, 0, 0, 2'd1));
        pulse_hw(0, 2);
        repeat (5) @(negedge clk);
        check("R12 busy stays low with enable off", busy, 0);

        // R9: reference settle gate
        reg_wr(2'd0, ctrl_w(1, 1, 0, 0, 1, 1, 2'd1));
        check("R9 reference enabled", {ref_enable, ref_level_hi}, 3);
        reg_rd(2'd2, d); check("R9 not ready right after enable", d[1], 0);
        pulse_hw(0, 2);
        repeat (5) @(negedge clk);
        check("R9 trigger ignored before ready", busy, 0);
        repeat (REF_CYC + 5) @(negedge clk);
        reg_rd(2'd2, d); check("R9 ready after settle", d[1], 1);
        vin_ch[0] = 13'd777;
        pulse_hw(0, 2);
        wait_done(200, td, ok);
        check("R9 conversion after settle", result, 777);
        repeat (10) @(negedge clk);
        check("R9 R8 reference stays on while core sleeps",
              {ref_enable, core_awake}, 2);
        reg_wr(2'd0, ctrl_w(1, 1, 0, 0, 0, 0, 2'd1));
        reg_rd(2'd2, d); check("R9 ready drops when reference off", d[1], 0);
        check("R9 reference off", ref_enable, 0);

        // R10: deferred clear of the conversion enable
        vin_ch[0] = 13'd1500;
        pulse_hw(0, 2);
        repeat (6) @(negedge clk);
        reg_wr(2'd0, ctrl_w(1, 0, 0, 0, 0, 0, 2'd1));
        reg_rd(2'd2, d); check("R10 enable held and pending while busy", d[3:2], 3);
        wait_done(200, td, ok);
        check("R10 result intact", result, 1500);
        repeat (2) @(negedge clk);
        reg_rd(2'd2, d); check("R10 enable cleared after completion", d[3:2], 0);
        pulse_hw(0, 2);
        repeat (5) @(negedge clk);
        check("R10 no start after clear", busy, 0);

        // R11: channel rewrite during sampling has no effect
        vin_ch[0] = 13'd500; vin_ch[6] = 13'd3000;
        reg_wr(2'd0, ctrl_w(1, 1, 0, 0, 0, 0, 2'd1));
        pulse_hw(0, 2);
        reg_wr(2'd1, clk_w(2'd0, 3'd0, 3'd6));
        check("R11 mux channel latched", mux_chan, 0);
        wait_done(200, td, ok);
        check("R11 result from latched channel", result, 500);
        // R7: result holds afterwards
        repeat (20) @(negedge clk);
        check("R7 result holds", result, 500);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule